// File: doc/BRIEF.md
# Combined forward/inverse AES byte substitution with tower-field inverter

This block substitutes one byte per cycle, in either direction of the AES S-box. A one-bit direction input chooses the direction for each beat. Forward beats are inverted in GF(2^8) and then passed through the forward affine transform. Inverse beats are passed through the inverse affine transform and then inverted. Both directions share one multiplicative inverter. The inverter has no lookup table. It works on a tower representation in which GF(2^2) is extended to GF(2^4) and then to GF(2^8), and each extension is a quadratic over the field below it.

A linear change of basis moves the operand from the AES polynomial field into the tower field. A second linear change of basis brings the result back. Both basis matrices are derived while the design elaborates: the design searches for a root of the AES field polynomial inside the tower field, and then inverts the resulting matrix over GF(2). No matrix constant is written out by hand.

The block is meant for a pipelined round datapath. A three-bit parameter places an optional register at each of three boundaries: after the forward basis change, after the inverter, and after the back conversion. The output valid follows the input valid by as many cycles as there are registers enabled.

Top module: `combined_sbox`

## Requirements
- R1: With `in_inv`=0, `out_byte` equals the AES S-box of `in_byte`. That value is the inverse of the byte modulo x^8+x^4+x^3+x+1, with 0 taken as its own inverse, followed by b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63. Here rotl rotates left within the byte and bit 0 is the least significant bit.
- R2: With `in_inv`=1, `out_byte` equals the inverse S-box of `in_byte`. The byte is first transformed to b' = rotl(b,1) ^ rotl(b,3) ^ rotl(b,6) ^ 0x05, and `out_byte` is the field inverse of b', with 0 mapping to 0.
- R3: The direction is taken per beat. Back-to-back beats with different `in_inv` values each get their own direction, with no dead cycles between them.
- R4: Zero is handled in the inverter. A forward beat of 0x00 gives 0x63, and an inverse beat of 0x63 gives 0x00.
- R5: For every byte x, feeding the forward result for x back in as an inverse beat gives x.
- R6: `out_valid` is `in_valid` delayed by the number of set bits in STAGE_REGS. Each output byte belongs to the beat that entered exactly that many cycles earlier. A result is produced only for a valid beat.
- R7: While `rst` is high at a rising clock edge, every enabled stage drops its valid. After reset, `out_valid` stays low until a new beat has had time to pass through.
- R8: No output equals its own input byte, and no output equals the bitwise complement of its input byte. This holds in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the stage valids |
| in_valid | input | 1 | The beat on `in_byte` is valid |
| in_inv | input | 1 | 0 selects the forward substitution, 1 selects the inverse |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | `out_byte` holds a result |
| out_byte | output | 8 | Substituted byte |

## Verification
All 256 bytes are sent in the forward direction and all 256 in the inverse direction, and each result is compared with a table the bench builds by brute-force field inversion. A wrong basis matrix, tower constant or affine constant therefore shows up on some byte. The forward outputs the design actually produced are then sent back as inverse beats; this separates a self-consistent but non-AES field from a correct one. A run that alternates direction on every beat, with bubbles scattered through it, tells apart direction or valid handling that slips by one stage. A reset taken with beats still in flight shows whether stale valids are cleared.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } dir_e;

    typedef struct packed {
        logic       vld;
        dir_e       dir;
        logic [7:0] val;
    } beat_t;

    typedef logic [7:0][7:0] bitmat_t;   // row r = output bit r

    localparam logic [7:0] FWD_AFF_C    = 8'h63;
    localparam logic [7:0] INV_AFF_C    = 8'h05;
    localparam logic [3:0] TOWER_LAMBDA = 4'b1100;   // x^2+x+lambda over GF(16)

    function automatic logic [7:0] rotl8(logic [7:0] b, int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] fwd_affine(logic [7:0] b);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ FWD_AFF_C;
    endfunction

    function automatic logic [7:0] inv_affine(logic [7:0] b);
        return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ INV_AFF_C;
    endfunction

    // GF(4): t^2 = t + 1
    function automatic logic [1:0] gf4_mul(logic [1:0] a, logic [1:0] b);
        return {(a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]),
                (a[1] & b[1]) ^ (a[0] & b[0])};
    endfunction

    function automatic logic [1:0] gf4_sq(logic [1:0] a);
        return {a[1], a[1] ^ a[0]};
    endfunction

    function automatic logic [1:0] gf4_mul_t(logic [1:0] a);
        return {a[1] ^ a[0], a[1]};
    endfunction

    // GF(16): u^2 = u + t
    function automatic logic [3:0] gf16_mul(logic [3:0] a, logic [3:0] b);
        logic [1:0] hh;
        hh = gf4_mul(a[3:2], b[3:2]);
        return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
                gf4_mul_t(hh) ^ gf4_mul(a[1:0], b[1:0])};
    endfunction

    function automatic logic [3:0] gf16_sq(logic [3:0] a);
        return gf16_mul(a, a);
    endfunction

    function automatic logic [3:0] gf16_inv(logic [3:0] a);
        logic [1:0] d, di;
        d  = gf4_mul_t(gf4_sq(a[3:2])) ^ gf4_mul(a[3:2], a[1:0]) ^ gf4_sq(a[1:0]);
        di = gf4_sq(d);                       // a^-1 = a^2 in GF(4)
        return {gf4_mul(a[3:2], di), gf4_mul(a[3:2] ^ a[1:0], di)};
    endfunction

    // GF(256): v^2 = v + lambda
    function automatic logic [7:0] gf256_mul(logic [7:0] a, logic [7:0] b);
        logic [3:0] hh;
        hh = gf16_mul(a[7:4], b[7:4]);
        return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
                gf16_mul(hh, TOWER_LAMBDA) ^ gf16_mul(a[3:0], b[3:0])};
    endfunction

    function automatic logic [7:0] mat_apply(bitmat_t m, logic [7:0] x);
        logic [7:0] y;
        for (int r = 0; r < 8; r++) y[r] = ^(m[r] & x);
        return y;
    endfunction

    // root of the AES field polynomial inside the tower field
    function automatic logic [7:0] find_root();
        logic [7:0] cv, p2, p4, ev, root;
        logic       found;
        root  = 8'h00;
        found = 1'b0;
        for (int c = 2; c < 256; c++) begin
            cv = 8'(c);
            p2 = gf256_mul(cv, cv);
            p4 = gf256_mul(p2, p2);
            ev = gf256_mul(p4, p4) ^ p4 ^ gf256_mul(p2, cv) ^ cv ^ 8'h01;
            if (!found && ev == 8'h00) begin
                root  = cv;
                found = 1'b1;
            end
        end
        return root;
    endfunction

    function automatic bitmat_t build_to_tower();
        bitmat_t    m;
        logic [7:0] pw, beta;
        beta = find_root();
        pw   = 8'h01;
        m    = '0;
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 8; r++) m[r][c] = pw[r];
            pw = gf256_mul(pw, beta);
        end
        return m;
    endfunction

    function automatic bitmat_t mat_invert(bitmat_t m);
        bitmat_t    a, b;
        logic [7:0] tmp;
        int         p;
        logic       found;
        a = m;
        for (int r = 0; r < 8; r++) b[r] = 8'h01 << r;
        for (int c = 0; c < 8; c++) begin
            p     = c;
            found = 1'b0;
            for (int r = c; r < 8; r++) begin
                if (!found && a[r][c]) begin
                    p     = r;
                    found = 1'b1;
                end
            end
            tmp = a[c]; a[c] = a[p]; a[p] = tmp;
            tmp = b[c]; b[c] = b[p]; b[p] = tmp;
            for (int r = 0; r < 8; r++) begin
                if (r != c && a[r][c]) begin
                    a[r] = a[r] ^ a[c];
                    b[r] = b[r] ^ b[c];
                end
            end
        end
        return b;
    endfunction

    localparam bitmat_t TO_TOWER   = build_to_tower();
    localparam bitmat_t FROM_TOWER = mat_invert(TO_TOWER);

endpackage

// File: rtl/sbox_front.sv
module sbox_front
    import sbox_pkg::*;
(
    input  beat_t din,
    output beat_t dout
);
    logic [7:0] pre;

    always_comb begin
        pre      = (din.dir == DIR_INV) ? inv_affine(din.val) : din.val;
        dout     = din;
        dout.val = mat_apply(TO_TOWER, pre);
    end
endmodule

// File: rtl/sbox_gf_inv.sv
module sbox_gf_inv
    import sbox_pkg::*;
(
    input  beat_t din,
    output beat_t dout
);
    logic [3:0] hi, lo, delta, delta_inv;

    always_comb begin
        hi        = din.val[7:4];
        lo        = din.val[3:0];
        delta     = gf16_mul(gf16_sq(hi), TOWER_LAMBDA) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);
        delta_inv = gf16_inv(delta);          // zero stays zero
        dout      = din;
        dout.val  = {gf16_mul(hi, delta_inv), gf16_mul(hi ^ lo, delta_inv)};
    end
endmodule

// File: rtl/sbox_back.sv
module sbox_back
    import sbox_pkg::*;
(
    input  beat_t din,
    output beat_t dout
);
    logic [7:0] field;

    always_comb begin
        field    = mat_apply(FROM_TOWER, din.val);
        dout     = din;
        dout.val = (din.dir == DIR_FWD) ? fwd_affine(field) : field;
    end
endmodule

// File: rtl/combined_sbox.sv
module combined_sbox
    import sbox_pkg::*;
#(
    parameter logic [2:0] STAGE_REGS = 3'b000   // bit k: register after stage k
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_inv,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    beat_t b_in;
    beat_t c_front, r_front;
    beat_t c_inv,   r_inv;
    beat_t c_back,  r_back;

    always_comb begin
        b_in.vld = in_valid;
        b_in.dir = dir_e'(in_inv);
        b_in.val = in_byte;
    end

    sbox_front  u_front (.din(b_in),    .dout(c_front));
    sbox_gf_inv u_inv   (.din(r_front), .dout(c_inv));
    sbox_back   u_back  (.din(r_inv),   .dout(c_back));

    if (STAGE_REGS[0]) begin : g_reg_front
        always_ff @(posedge clk) begin
            if (rst) r_front.vld <= 1'b0;
            else     r_front     <= c_front;
        end
    end else begin : g_pass_front
        assign r_front = c_front;
    end

    if (STAGE_REGS[1]) begin : g_reg_inv
        always_ff @(posedge clk) begin
            if (rst) r_inv.vld <= 1'b0;
            else     r_inv     <= c_inv;
        end
    end else begin : g_pass_inv
        assign r_inv = c_inv;
    end

    if (STAGE_REGS[2]) begin : g_reg_back
        always_ff @(posedge clk) begin
            if (rst) r_back.vld <= 1'b0;
            else     r_back     <= c_back;
        end
    end else begin : g_pass_back
        assign r_back = c_back;
    end

    assign out_valid = r_back.vld;
    assign out_byte  = r_back.val;
endmodule

// File: rtl/sbox_checker.sv
module sbox_checker #(
    parameter logic [2:0] STAGE_REGS = 3'b000
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_inv,
    input logic [7:0] in_byte,
    input logic       out_valid,
    input logic [7:0] out_byte
);
    localparam int LAT = $countones(STAGE_REGS);

    logic       d_vld;
    logic       d_inv;
    logic [7:0] d_byte;

    if (LAT == 0) begin : g_nodelay
        assign d_vld  = in_valid;
        assign d_inv  = in_inv;
        assign d_byte = in_byte;
    end else begin : g_delay
        logic [LAT-1:0] sh_vld;
        logic [LAT-1:0] sh_inv;
        logic [7:0]     sh_byte [LAT];
        always_ff @(posedge clk) begin
            if (rst) sh_vld <= '0;
            else     sh_vld <= {sh_vld[LAT-1:0], in_valid} >> 0;
        end
        always_ff @(posedge clk) begin
            sh_inv     <= {sh_inv[LAT-1:0], in_inv} >> 0;
            sh_byte[0] <= in_byte;
            for (int k = 1; k < LAT; k++) sh_byte[k] <= sh_byte[k-1];
        end
        assign d_vld  = sh_vld[LAT-1];
        assign d_inv  = sh_inv[LAT-1];
        assign d_byte = sh_byte[LAT-1];
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        out_valid == d_vld) else $error("valid latency");                       // R6
    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_byte)) else $error("unknown output");     // R1
    AST_ZERO_FWD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !d_inv && d_byte == 8'h00) |-> out_byte == 8'h63)
        else $error("forward zero");                                           // R4
    AST_ZERO_INV: assert property (@(posedge clk) disable iff (rst)
        (out_valid && d_inv && d_byte == 8'h63) |-> out_byte == 8'h00)
        else $error("inverse zero");                                           // R4
    AST_NO_FIXED_POINT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_byte != d_byte) else $error("fixed point");           // R8
    AST_NO_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_byte != ~d_byte) else $error("complement point");     // R8
endmodule

bind combined_sbox sbox_checker #(.STAGE_REGS(STAGE_REGS)) u_sbox_checker (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_inv   (in_inv),
    .in_byte  (in_byte),
    .out_valid(out_valid),
    .out_byte (out_byte)
);

// File: tb/tb_combined_sbox.sv
module tb_combined_sbox;
    localparam logic [2:0] REGS = 3'b111;
    localparam int         LAT  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_inv = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;

    always #4 clk = ~clk;   // 125 MHz

    combined_sbox #(.STAGE_REGS(REGS)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_inv(in_inv),
        .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte)
    );

    typedef struct {
        logic       inv;
        logic [7:0] din;
        logic [7:0] exp;
        int         due;
        string      tag;
    } item_t;

    item_t      q[$];
    int         checks = 0;
    int         fails  = 0;
    int         cyc    = 0;
    logic       flushing = 1'b0;
    logic [7:0] ref_sb  [256];
    logic [7:0] ref_isb [256];
    logic [7:0] got_fwd [256];

    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] ginv(logic [7:0] a);
        logic [7:0] r = 8'h00;
        for (int y = 1; y < 256; y++) if (gmul(a, 8'(y)) == 8'h01) r = 8'(y);
        return r;
    endfunction

    function automatic logic [7:0] ref_fwd_aff(logic [7:0] b);
        logic [7:0] o;
        for (int i = 0; i < 8; i++)
            o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
        return o ^ 8'h63;
    endfunction

    function automatic logic [7:0] ref_inv_aff(logic [7:0] b);
        logic [7:0] o;
        for (int i = 0; i < 8; i++)
            o[i] = b[(i+2)%8] ^ b[(i+5)%8] ^ b[(i+7)%8];
        return o ^ 8'h05;
    endfunction

    task automatic send(input bit inv, input logic [7:0] v, input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_inv   = inv;
        in_byte  = v;
        it.inv = inv; it.din = v; it.exp = exp; it.due = cyc + LAT; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        while (q.size() != 0) idle();
        repeat (3) idle();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #2;
        if (!flushing && out_valid === 1'b1) begin
            if (q.size() == 0) begin
                chk(1'b0, "R6 output without a pending beat", out_byte, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(out_byte === it.exp, it.tag, out_byte, it.exp);
                chk(cyc == it.due, "R6 latency", cyc, it.due);
                chk(out_byte !== it.din && out_byte !== ~it.din, "R8 fixed/complement", out_byte, it.din);
                if (!it.inv) got_fwd[it.din] = out_byte;
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, 30000);
        finish_run();
    end

    initial begin
        for (int x = 0; x < 256; x++) begin
            ref_sb[x]  = ref_fwd_aff(ginv(8'(x)));
            ref_isb[x] = ginv(ref_inv_aff(8'(x)));
            got_fwd[x] = 8'h00;
        end

        // R7: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #3;
        chk(out_valid === 1'b0, "R7 idle after reset", out_valid, 0);

        // R4: zero corners
        send(1'b0, 8'h00, 8'h63, "R4 fwd zero");
        send(1'b1, 8'h63, 8'h00, "R4 inv of 0x63");
        drain();

        // R1: full forward sweep
        for (int x = 0; x < 256; x++) send(1'b0, 8'(x), ref_sb[x], "R1 forward");
        // R2: full inverse sweep
        for (int x = 0; x < 256; x++) send(1'b1, 8'(x), ref_isb[x], "R2 inverse");
        drain();

        // R5: feed the design's own forward outputs back
        for (int x = 0; x < 256; x++) send(1'b1, got_fwd[x], 8'(x), "R5 round trip");
        drain();

        // R3 / R6: direction alternating every beat, with bubbles
        for (int i = 0; i < 96; i++) begin
            logic [7:0] v;
            v = 8'(i * 37 + 11);
            if (i[0]) send(1'b1, v, ref_isb[v], "R3 mixed inverse");
            else      send(1'b0, v, ref_sb[v],  "R3 mixed forward");
            if (i % 5 == 0) idle();
        end
        drain();

        // R7: reset with beats in flight
        send(1'b0, 8'h53, ref_sb[8'h53], "R7 in flight");
        send(1'b1, 8'hED, ref_isb[8'hED], "R7 in flight");
        @(negedge clk);
        rst      = 1'b1;
        flushing = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        q.delete();
        rst      = 1'b0;
        flushing = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #3;
            chk(out_valid === 1'b0, "R7 flushed", out_valid, 0);
        end

        finish_run();
    end
endmodule